// File: doc/BRIEF.md
# Scrolling LED Matrix Message Driver

This block drives an 8x8 LED matrix that is lit one column at a time. It scrolls a fixed bitmap message across the matrix from right to left. A free-running clock is divided into a slow tick. Successive ticks alternate between two phases. In the first phase the active column moves on by one place. In the second phase a scroll counter advances, and after a set number of counts the whole message shifts by one column.

The message is a circular buffer of column bytes, eight bytes per character. The column byte fed to the active column is taken from the top of the buffer, offset by the column's position. Both output buses come from registers and change on the same clock edge, so a column never shows the row data meant for its neighbour.

The prescaler is a two-state machine:
- State `PH_ADVANCE`: a tick moves it to `PH_COUNT` and rotates the column.
- State `PH_COUNT`: a tick moves it back to `PH_ADVANCE` and bumps the scroll counter.
- Scroll counter: when it wraps from `SCROLL_DIV-1` to zero, the message rotates.

Top module: `led_scroll_drv`

## Requirements
- R1: While `rst` is high at a clock edge, all of the following happen. `col_o` becomes 8'b0000_0001. `row_o` becomes the top byte of `MSG_INIT` (bits [W-1:W-8], where W = 64*N_CHARS). The tick count, the phase and the scroll count all restart.
- R2: Out of reset, exactly one bit of `col_o` is high in every cycle. `row_o` is nonzero only while `col_o` is one-hot.
- R3: The first column rotation comes `TICK_DIV` cycles after reset is released. After that, `col_o` rotates left by one place (bit 7 wraps to bit 0) once every 2*`TICK_DIV` cycles.
- R4: When bit k of `col_o` is high, `row_o` equals byte k counted from the top of the current message, that is bits [W-1-8k -: 8].
- R5: The message rotates left by 8 bits once every 2*`TICK_DIV`*`SCROLL_DIV` cycles. The first rotation comes that many cycles after reset is released.
- R6: After 8*`N_CHARS` scroll steps, the message is again equal to `MSG_INIT`.
- R7: A reset raised in the middle of a run restarts both the column scan and the scroll from their initial state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| col_o | output | 8 | One-hot column enable, active high |
| row_o | output | 8 | Row data for the active column, active high |

## Verification
The hardest condition to reach from the ports is the wrap of the message after a full lap of scroll steps. It needs thousands of scan periods at full-size divisors. The bench therefore shrinks the tick and scroll divisors, so that one lap lasts only a few hundred cycles. It loads a message whose 32 column bytes are all different, so that any off-by-one in the scroll or in the column-to-byte mapping gives a wrong row byte. Random run lengths and random mid-run resets land samples just before and just after each phase tick and scroll step.

// File: rtl/lsd_pkg.sv
`timescale 1ns/1ps
package lsd_pkg;
    // Phase of the slow tick: the first tick of each pair advances the
    // column, the second feeds the scroll counter.
    typedef enum logic {
        PH_ADVANCE = 1'b0,
        PH_COUNT   = 1'b1
    } phase_t;

    localparam int COL_N = 8;
endpackage

// File: rtl/lsd_prescale.sv
`timescale 1ns/1ps
module lsd_prescale
    import lsd_pkg::*;
#(
    parameter int TICK_DIV   = 25000,
    parameter int SCROLL_DIV = 125
) (
    input  logic clk,
    input  logic rst,
    output logic col_step,
    output logic scroll_step
);
    localparam int TW = (TICK_DIV   > 1) ? $clog2(TICK_DIV)   : 1;
    localparam int SW = (SCROLL_DIV > 1) ? $clog2(SCROLL_DIV) : 1;

    logic [TW-1:0] tcnt_q;
    logic [SW-1:0] scnt_q;
    phase_t        ph_q, ph_nxt;
    logic          tick, cnt_evt;

    assign tick = (tcnt_q == TW'(TICK_DIV - 1));

    // state register, tick counter and scroll counter
    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt_q <= '0;
            scnt_q <= '0;
            ph_q   <= PH_ADVANCE;
        end else begin
            tcnt_q <= tick ? '0 : tcnt_q + 1'b1;
            ph_q   <= ph_nxt;
            if (cnt_evt)
                scnt_q <= (scnt_q == SW'(SCROLL_DIV - 1)) ? '0 : scnt_q + 1'b1;
        end
    end

    // transitions and step outputs
    always_comb begin
        ph_nxt   = ph_q;
        col_step = 1'b0;
        cnt_evt  = 1'b0;
        if (tick) begin
            unique case (ph_q)
                PH_ADVANCE: begin
                    ph_nxt   = PH_COUNT;
                    col_step = 1'b1;
                end
                PH_COUNT: begin
                    ph_nxt  = PH_ADVANCE;
                    cnt_evt = 1'b1;
                end
            endcase
        end
        scroll_step = cnt_evt && (scnt_q == SW'(SCROLL_DIV - 1));
    end
endmodule

// File: rtl/lsd_col_scan.sv
`timescale 1ns/1ps
module lsd_col_scan
    import lsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             col_step,
    output logic [COL_N-1:0] col_nxt,
    output logic [COL_N-1:0] col_q
);
    always_comb begin
        if (rst)
            col_nxt = COL_N'(1);
        else if (col_step)
            col_nxt = {col_q[COL_N-2:0], col_q[COL_N-1]};
        else
            col_nxt = col_q;
    end

    always_ff @(posedge clk)
        col_q <= col_nxt;
endmodule

// File: rtl/lsd_msg_buf.sv
`timescale 1ns/1ps
module lsd_msg_buf #(
    parameter int          W        = 256,
    parameter logic [W-1:0] MSG_INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scroll_step,
    output logic [W-1:0] msg_nxt
);
    logic [W-1:0] msg_q;

    always_comb begin
        if (rst)
            msg_nxt = MSG_INIT;
        else if (scroll_step)
            msg_nxt = {msg_q[W-9:0], msg_q[W-1 -: 8]};
        else
            msg_nxt = msg_q;
    end

    always_ff @(posedge clk)
        msg_q <= msg_nxt;
endmodule

// File: rtl/led_scroll_drv.sv
`timescale 1ns/1ps
module led_scroll_drv
    import lsd_pkg::*;
#(
    parameter int TICK_DIV   = 25000,
    parameter int SCROLL_DIV = 125,
    parameter int N_CHARS    = 4,
    parameter logic [N_CHARS*64-1:0] MSG_INIT =
        256'h007E_9090_907E_0000_00FE_9292_926C_0000_007C_8282_8244_0000_0000_0000_0000_0000
) (
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] col_o,
    output logic [7:0] row_o
);
    localparam int W = N_CHARS * 64;

    logic             col_step, scroll_step;
    logic [COL_N-1:0] col_nxt;
    logic [W-1:0]     msg_nxt;
    logic [7:0]       hit [COL_N];
    logic [7:0]       row_nxt;
    logic [7:0]       row_q;

    lsd_prescale #(.TICK_DIV(TICK_DIV), .SCROLL_DIV(SCROLL_DIV)) u_pre (
        .clk(clk), .rst(rst), .col_step(col_step), .scroll_step(scroll_step)
    );

    lsd_col_scan u_col (
        .clk(clk), .rst(rst), .col_step(col_step), .col_nxt(col_nxt), .col_q(col_o)
    );

    lsd_msg_buf #(.W(W), .MSG_INIT(MSG_INIT)) u_msg (
        .clk(clk), .rst(rst), .scroll_step(scroll_step), .msg_nxt(msg_nxt)
    );

    // One decoder per column. A column byte is picked only on an exact
    // one-hot match, so any other column value gives zero rows.
    for (genvar k = 0; k < COL_N; k++) begin : g_sel
        assign hit[k] = (col_nxt == COL_N'(1 << k)) ? msg_nxt[W-1-8*k -: 8] : 8'h00;
    end

    always_comb begin
        row_nxt = 8'h00;
        for (int k = 0; k < COL_N; k++)
            row_nxt = row_nxt | hit[k];
    end

    // Registered together with the column register, so both buses move on one edge.
    always_ff @(posedge clk)
        row_q <= row_nxt;

    assign row_o = row_q;
endmodule

// File: rtl/lsd_checker.sv
`timescale 1ns/1ps
module lsd_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] col_o,
    input logic [7:0] row_o
);
    logic       rst_d;
    logic [7:0] col_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        col_d <= col_o;
    end

    // R1
    reset_col_home_chk: assert property (@(posedge clk) rst |=> (col_o == 8'h01));

    // R2
    col_onehot_chk: assert property (@(posedge clk) disable iff (rst || rst_d)
        $onehot(col_o));

    // R2
    row_only_active_chk: assert property (@(posedge clk) disable iff (rst || rst_d)
        (row_o != 8'h00) |-> ($countones(col_o) == 1));

    // R3
    col_rotate_chk: assert property (@(posedge clk) disable iff (rst || rst_d)
        !$stable(col_o) |-> (col_o == {col_d[6:0], col_d[7]}));
endmodule

bind led_scroll_drv lsd_checker u_chk (
    .clk(clk), .rst(rst), .col_o(col_o), .row_o(row_o)
);

// File: tb/led_scroll_drv_test.sv
`timescale 1ns/1ps
module led_scroll_drv_test;
    localparam int TD = 4;
    localparam int SD = 3;
    localparam int NC = 4;
    localparam int W  = NC * 64;
    localparam int NB = W / 8;

    function automatic logic [W-1:0] make_msg();
        logic [W-1:0] m;
        for (int i = 0; i < NB; i++)
            m[W-1-8*i -: 8] = 8'(i * 29 + 3) ^ 8'h5A;
        return m;
    endfunction

    localparam logic [W-1:0] TB_MSG = make_msg();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] col_o, row_o;
    int         vectors = 0;
    int         failures = 0;
    int         e = 0;   // clock edges since reset release

    always #10 clk = ~clk;

    led_scroll_drv #(.TICK_DIV(TD), .SCROLL_DIV(SD), .N_CHARS(NC), .MSG_INIT(TB_MSG)) uut (
        .clk(clk), .rst(rst), .col_o(col_o), .row_o(row_o)
    );

    function automatic logic [W-1:0] exp_msg(int edges);
        int steps = (edges / (2 * TD * SD)) % NB;
        logic [W-1:0] m = TB_MSG;
        for (int s = 0; s < steps; s++)
            m = {m[W-9:0], m[W-1 -: 8]};
        return m;
    endfunction

    function automatic int exp_ci(int edges);
        return ((edges / TD + 1) / 2) % 8;
    endfunction

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        e = 0;
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            e++;
        end
    endtask

    task automatic check_out(string req);
        int           ci = exp_ci(e);
        logic [W-1:0] m  = exp_msg(e);
        logic [7:0]   ec = 8'(1 << ci);
        logic [7:0]   er = m[W-1-8*ci -: 8];
        vectors++;
        if (col_o !== ec || row_o !== er) begin
            failures++;
            $display("FAIL %s at edge %0d: col=%b row=%h expected col=%b row=%h",
                     req, e, col_o, row_o, ec, er);
        end
    endtask

    task automatic check_onehot();
        vectors++;
        if ($countones(col_o) != 1) begin
            failures++;
            $display("FAIL R2 col=%b expected exactly one bit high", col_o);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e = 0;

        // R1: reset state
        check_out("R1 reset");

        // R3 / R4: rotation order and byte per column, just before and at each advance
        for (int j = 1; j <= 9; j++) begin
            step(TD * (2 * j - 1) - 1 - e);
            check_out("R3 hold");
            step(1);
            check_out("R3/R4 advance");
        end

        // R5: first scroll step boundary
        do_reset();
        step(2 * TD * SD - 1);
        check_out("R5 before scroll");
        step(1);
        check_out("R5 after scroll");

        // R6: wrap after one full lap of the buffer
        do_reset();
        step(NB * 2 * TD * SD - 1);
        check_out("R6 last before wrap");
        step(1);
        check_out("R6 wrap");
        for (int k = 0; k < 8; k++) begin
            step(2 * TD);
            check_out("R6/R4 frame after wrap");
        end

        // R7: reset in the middle of a run
        do_reset();
        step(5 * 2 * TD * SD + 7);
        do_reset();
        check_out("R7 mid-run reset");
        step(2 * TD * SD);
        check_out("R7 scroll restart");

        // random run lengths with random resets
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 19) == 0) begin
                do_reset();
                check_out("R7 random reset");
            end
            step($urandom_range(1, 40));
            check_onehot();
            check_out("R3/R4/R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end
endmodule